// File: doc/BRIEF.md
# Double-Precision Square Root Unit

This block computes the square root of one binary64 operand with round-to-nearest-even. A one-cycle start pulse hands the operand over. Some time later the unit raises a one-cycle done pulse and presents the 64-bit result together with two exception flags: one for an invalid square root and one for a signalling-NaN operand. Special operands (zeros, infinities, NaNs, negative numbers) finish in the cycle after start. All other operands run through an iterative mantissa datapath. That datapath uses a single shared 64x64 multiplier, so the latency is fixed by the sequence of states.

For a finite positive operand, the unit first normalises denormals. When the unbiased exponent is odd, it doubles the mantissa so that the exponent becomes even. It reads an inverse-square-root seed from a computed table indexed by exponent parity and the leading mantissa bits. It then runs three coupled Newton steps: `p = 1.5 - h*r`, then `h = h*p`, then `r = r*p`, where `r` tends to the root and `h` to half its reciprocal. The refined root is truncated to 54 bits (53 bits plus a guard bit) and squared. The remainder is then compared with `2S+1` and corrected in steps until the candidate is the exact integer floor of the root; that comparison also yields the sticky bit. The last state rounds and packs the result. The result exponent is the unbiased operand exponent shifted right arithmetically by one.

States: `ST_IDLE` goes to `ST_SEED` on start with an ordinary operand (with a special operand it stays in `ST_IDLE` and posts the result at once). `ST_SEED` goes to `ST_NR_P`. `ST_NR_P` goes to `ST_NR_H`, and `ST_NR_H` goes to `ST_NR_R`. `ST_NR_R` loops back to `ST_NR_P` until three steps are done, then goes to `ST_REM`. `ST_REM` goes to `ST_FIX`. `ST_FIX` stays in `ST_FIX` while the remainder is negative or at least `2S+1`, then goes to `ST_ROUND`. `ST_ROUND` goes to `ST_IDLE` and raises done.

Top module: `fp64_sqrt`

## Requirements
- R1: A negative operand that is finite and non-zero, or negative infinity, yields 0x7ff8000000000000 with invalid_sqrt_o = 1 and invalid_snan_o = 0.
- R2: +0, -0, +infinity and any quiet NaN (exponent field all ones, bit 51 set) are returned bit-for-bit unchanged with both flags clear.
- R3: A signalling NaN (exponent field all ones, bit 51 clear, fraction non-zero) is returned with bit 51 set and all other bits unchanged, with invalid_snan_o = 1 and invalid_sqrt_o = 0.
- R4: For a positive normal operand the result equals the correctly rounded (nearest, ties to even) binary64 square root, with both flags clear, e.g. sqrt(3.0) = 0x3ffbb67ae8584caa.
- R5: Positive denormal operands are normalised first and give the correctly rounded root: 0x1 gives 0x1e60000000000000 and 0x2 gives 0x1e66a09e667f3bcd.
- R6: Operands with an odd unbiased exponent give the correctly rounded root: 2.0 gives 0x3ff6a09e667f3bcd and 0x0008000000000000 gives 0x1ff6a09e667f3bcd.
- R7: done_o is a one-cycle pulse, one per accepted start. It comes one cycle after start for a special operand and within 40 cycles for any other operand, and it is never high while the unit is busy.
- R8: A start pulse that arrives while a computation is in progress is ignored: no extra done is produced and the result belongs to the first operand.
- R9: result_o, invalid_sqrt_o and invalid_snan_o change only in the cycle in which done_o rises, and otherwise keep their values.
- R10: After reset, done_o, result_o and both flags are zero.
- R11: invalid_sqrt_o and invalid_snan_o are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| operand_i | input | 64 | Binary64 operand, sampled with start_i |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Binary64 square root, held until the next completion |
| invalid_sqrt_o | output | 1 | Square root of a negative value was requested |
| invalid_snan_o | output | 1 | Operand was a signalling NaN |

## Verification
The assertions assume that start_i and operand_i are driven to known values at every clock edge after reset. They also assume that reset is held from time zero across at least one edge. The latency assertion relies on the remainder fix-up settling within a few cycles, which holds only while the seed table and Newton steps keep their precision. The stimulus drives every input at the falling edge and holds start_i low except for deliberate one-cycle pulses. The random operands are drawn from classes (normal, denormal, special, negative, NaN) so that every class of the requirements is reached.

// File: rtl/fp64_sqrt_pkg.sv
package fp64_sqrt_pkg;

    localparam int unsigned DW       = 64;   // operand width
    localparam int unsigned EW       = 11;   // exponent field width
    localparam int unsigned FW       = 52;   // fraction field width
    localparam int unsigned XW       = 13;   // signed unbiased exponent width
    localparam int          BIAS     = 1023;
    localparam int unsigned FXW      = 64;   // fixed-point word, 2 integer bits
    localparam int unsigned FXF      = 62;   // fraction bits of the fixed-point word
    localparam int unsigned SEED_IW  = 8;    // seed index: parity + 7 mantissa bits
    localparam int unsigned SEED_W   = 14;   // seed fraction bits
    localparam int unsigned NR_STEPS = 3;
    localparam int unsigned SW       = FW + 3;           // root candidate width (55)
    localparam int unsigned RW       = 2 * (FW + 4);     // remainder width (112)
    localparam int unsigned PW       = 126;              // kept product width

    localparam logic [DW-1:0] QNAN_DEFAULT = 64'h7ff8_0000_0000_0000;
    localparam logic [FXW-1:0] FX_THREE_HALVES = 64'h6000_0000_0000_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_NR_P,
        ST_NR_H,
        ST_NR_R,
        ST_REM,
        ST_FIX,
        ST_ROUND
    } sq_state_e;

    typedef struct packed {
        logic          sign;
        logic          is_zero;
        logic          is_inf;
        logic          is_nan;
        logic          is_snan;
        logic [XW-1:0] exp;     // two's complement unbiased exponent
        logic [FW:0]   mant;    // normalised 1.52 mantissa
    } sq_unpacked_t;

endpackage

// File: rtl/fp64_sqrt_unpack.sv
module fp64_sqrt_unpack
    import fp64_sqrt_pkg::*;
(
    input  logic [DW-1:0]  op_i,
    output sq_unpacked_t   up_o
);

    logic [EW-1:0] biased;
    logic [FW-1:0] frac;
    logic [5:0]    lz;

    assign biased = op_i[DW-2 -: EW];
    assign frac   = op_i[FW-1:0];

    always_comb begin
        lz = '0;
        for (int i = 0; i < FW; i++) begin
            if (frac[i]) lz = 6'(FW - 1 - i);
        end
    end

    always_comb begin
        up_o.sign    = op_i[DW-1];
        up_o.is_zero = (biased == '0) && (frac == '0);
        up_o.is_inf  = (biased == '1) && (frac == '0);
        up_o.is_nan  = (biased == '1) && (frac != '0);
        up_o.is_snan = (biased == '1) && (frac != '0) && !frac[FW-1];
        if (biased != '0) begin
            up_o.mant = {1'b1, frac};
            up_o.exp  = XW'(int'(biased) - BIAS);
        end else begin
            up_o.mant = (FW+1)'({1'b0, frac} << (lz + 6'd1));
            up_o.exp  = XW'(-BIAS - int'(lz));
        end
    end

endmodule

// File: rtl/fp64_sqrt_seed_rom.sv
module fp64_sqrt_seed_rom #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OUT_W = 14
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [OUT_W-1:0] seed_o
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    // Largest y (OUT_W fraction bits) with y*y*a <= 1, a taken at the centre
    // of the interval selected by the index (scaled by 2^IDX_W).
    function automatic logic [OUT_W-1:0] seed_of(input int unsigned k);
        longint a_mid;
        longint lim;
        longint y;
        longint c;
        longint t;
        t = longint'(k) & ((longint'(1) << (IDX_W - 1)) - 1);
        if (((k >> (IDX_W - 1)) & 1) != 0)
            a_mid = (longint'(1) << (IDX_W + 1)) + 4 * t + 2;
        else
            a_mid = (longint'(1) << IDX_W) + 2 * t + 1;
        lim = longint'(1) << (2 * OUT_W + IDX_W);
        y = 0;
        for (int b = OUT_W - 1; b >= 0; b--) begin
            c = y | (longint'(1) << b);
            if (c * c * a_mid <= lim) y = c;
        end
        return OUT_W'(y);
    endfunction

    logic [OUT_W-1:0] table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam logic [OUT_W-1:0] VAL = seed_of(g);
        assign table_w[g] = VAL;
    end

    assign seed_o = table_w[idx_i];

endmodule

// File: rtl/fp64_sqrt_mul.sv
module fp64_sqrt_mul #(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 126
) (
    input  logic [IN_W-1:0]  a_i,
    input  logic [IN_W-1:0]  b_i,
    output logic [OUT_W-1:0] p_o
);

    assign p_o = OUT_W'({{IN_W{1'b0}}, a_i} * {{IN_W{1'b0}}, b_i});

endmodule

// File: rtl/fp64_sqrt.sv
module fp64_sqrt
    import fp64_sqrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [63:0]   operand_i,
    output logic          done_o,
    output logic [63:0]   result_o,
    output logic          invalid_sqrt_o,
    output logic          invalid_snan_o
);

    sq_state_e state_q, state_d;
    sq_unpacked_t up;

    logic [FW+1:0]          a_q;       // a * 2^52, a in [1,4)
    logic signed [XW-1:0]   exp_q;
    logic [FXW-1:0]         r_q, h_q, p_q;
    logic [SW-1:0]          s_q;
    logic signed [RW-1:0]   rem_q;
    logic [1:0]             step_q;
    logic                   sticky_q;
    logic [DW-1:0]          res_q;
    logic                   done_q, inv_q, snan_q;
    logic                   busy;

    logic [SEED_IW-1:0]     seed_idx;
    logic [SEED_W-1:0]      seed;
    logic [FXW-1:0]         mul_a, mul_b;
    logic [PW-1:0]          prod;
    logic [FXW-1:0]         prod_fx;
    logic                   special;
    logic [DW-1:0]          spec_res;
    logic signed [RW-1:0]   twos;
    logic                   in_range;
    logic                   round_up;
    logic [FW+1:0]          sig_sum;
    logic signed [XW-1:0]   half_exp;
    logic [EW-1:0]          res_exp;

    fp64_sqrt_unpack u_unpack (.op_i(operand_i), .up_o(up));

    assign seed_idx = a_q[FW+1] ? {1'b1, a_q[FW -: SEED_IW-1]}
                                : {1'b0, a_q[FW-1 -: SEED_IW-1]};

    fp64_sqrt_seed_rom #(.IDX_W(SEED_IW), .OUT_W(SEED_W)) u_rom (
        .idx_i(seed_idx), .seed_o(seed)
    );

    fp64_sqrt_mul #(.IN_W(FXW), .OUT_W(PW)) u_mul (
        .a_i(mul_a), .b_i(mul_b), .p_o(prod)
    );

    assign prod_fx = prod[FXF+FXW-1:FXF];
    assign busy    = (state_q != ST_IDLE);

    // operand selection for the shared multiplier
    always_comb begin
        unique case (state_q)
            ST_SEED:  begin mul_a = {2'b0, seed, 48'b0}; mul_b = {a_q, 10'b0}; end
            ST_NR_P:  begin mul_a = h_q; mul_b = r_q; end
            ST_NR_H:  begin mul_a = h_q; mul_b = p_q; end
            ST_NR_R:  begin mul_a = r_q; mul_b = p_q; end
            ST_REM:   begin mul_a = {9'b0, r_q[FXW-1:9]}; mul_b = {9'b0, r_q[FXW-1:9]}; end
            default:  begin mul_a = '0; mul_b = '0; end
        endcase
    end

    // special operands
    always_comb begin
        special  = up.is_nan || up.is_zero || up.is_inf || up.sign;
        spec_res = operand_i;
        if (up.is_nan)       spec_res = operand_i | (64'd1 << (FW - 1));
        else if (up.is_zero) spec_res = operand_i;
        else if (up.sign)    spec_res = QNAN_DEFAULT;
    end

    // remainder window and rounding
    assign twos     = $signed({{(RW-SW-1){1'b0}}, s_q, 1'b1});
    assign in_range = !rem_q[RW-1] && (rem_q < twos);
    assign round_up = s_q[0] & (sticky_q | s_q[1]);
    assign sig_sum  = {1'b0, s_q[FW+1:1]} + {{(FW+1){1'b0}}, round_up};
    assign half_exp = exp_q >>> 1;
    assign res_exp  = EW'(half_exp + XW'(BIAS) + XW'(sig_sum[FW+1]));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i && !special) state_d = ST_SEED;
            ST_SEED:  state_d = ST_NR_P;
            ST_NR_P:  state_d = ST_NR_H;
            ST_NR_H:  state_d = ST_NR_R;
            ST_NR_R:  state_d = (step_q == 2'(NR_STEPS - 1)) ? ST_REM : ST_NR_P;
            ST_REM:   state_d = ST_FIX;
            ST_FIX:   if (in_range) state_d = ST_ROUND;
            ST_ROUND: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0; exp_q <= '0; r_q <= '0; h_q <= '0; p_q <= '0;
            s_q <= '0; rem_q <= '0; step_q <= '0; sticky_q <= 1'b0;
            res_q <= '0; done_q <= 1'b0; inv_q <= 1'b0; snan_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    if (special) begin
                        res_q  <= spec_res;
                        inv_q  <= up.sign && !up.is_nan && !up.is_zero;
                        snan_q <= up.is_snan;
                        done_q <= 1'b1;
                    end else begin
                        a_q    <= up.exp[0] ? {up.mant, 1'b0} : {1'b0, up.mant};
                        exp_q  <= $signed(up.exp);
                        step_q <= '0;
                    end
                end
                ST_SEED: begin
                    r_q <= prod_fx;
                    h_q <= {3'b0, seed, 47'b0};
                end
                ST_NR_P: p_q <= FX_THREE_HALVES - prod_fx;
                ST_NR_H: h_q <= prod_fx;
                ST_NR_R: begin
                    r_q    <= prod_fx;
                    step_q <= step_q + 2'd1;
                end
                ST_REM: begin
                    s_q   <= r_q[FXW-1:9];
                    rem_q <= $signed({4'b0, a_q, {(FW+2){1'b0}}}) - $signed(prod[RW-1:0]);
                end
                ST_FIX: begin
                    if (rem_q[RW-1]) begin
                        s_q   <= s_q - 1'b1;
                        rem_q <= rem_q + twos - RW'(2);
                    end else if (!in_range) begin
                        s_q   <= s_q + 1'b1;
                        rem_q <= rem_q - twos;
                    end else begin
                        sticky_q <= (rem_q != '0);
                    end
                end
                ST_ROUND: begin
                    res_q  <= {1'b0, res_exp, sig_sum[FW-1:0]};
                    inv_q  <= 1'b0;
                    snan_q <= 1'b0;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    assign done_o         = done_q;
    assign result_o       = res_q;
    assign invalid_sqrt_o = inv_q;
    assign invalid_snan_o = snan_q;

endmodule

// File: rtl/fp64_sqrt_chk.sv
module fp64_sqrt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done_o,
    input logic [63:0] result_o,
    input logic        invalid_sqrt_o,
    input logic        invalid_snan_o,
    input logic        busy
);

    logic [5:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        busy_cnt <= '0;
        else if (!busy)                    busy_cnt <= '0;
        else if (busy_cnt != 6'h3f)        busy_cnt <= busy_cnt + 6'd1;
    end

    a_r7_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt < 6'd40);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({result_o, invalid_sqrt_o, invalid_snan_o}));

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid_sqrt_o && invalid_snan_o));

    a_r1_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_sqrt_o |-> (result_o == 64'h7ff8_0000_0000_0000));

    a_r3_quietened: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_snan_o |-> (result_o[62:51] == 12'hfff));

    a_r4_only_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o[63] && result_o[62:52] != 11'h7ff) |-> (result_o[62:0] == 63'd0));

endmodule

bind fp64_sqrt fp64_sqrt_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .done_o         (done_o),
    .result_o       (result_o),
    .invalid_sqrt_o (invalid_sqrt_o),
    .invalid_snan_o (invalid_snan_o),
    .busy           (busy)
);

// File: tb/fp64_sqrt_tb.sv
`timescale 1ns/1ps
module fp64_sqrt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic        done_o;
    logic [63:0] result_o;
    logic        invalid_sqrt_o;
    logic        invalid_snan_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    fp64_sqrt u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .done_o(done_o), .result_o(result_o),
        .invalid_sqrt_o(invalid_sqrt_o), .invalid_snan_o(invalid_snan_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL R7 watchdog expired: actual=%0d cycles expected<150000", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_special(input logic [63:0] x);
        return (x[62:52] == 11'h7ff) || (x[62:0] == '0) || x[63];
    endfunction

    function automatic logic [63:0] model_res(input logic [63:0] x);
        if (x[62:52] == 11'h7ff && x[51:0] != '0) return x | (64'd1 << 51);
        if (x[62:0] == '0) return x;
        if (x[63]) return 64'h7ff8_0000_0000_0000;
        if (x[62:52] == 11'h7ff) return x;
        return $realtobits($sqrt($bitstoreal(x)));
    endfunction

    function automatic logic [1:0] model_flags(input logic [63:0] x);
        logic nan;
        nan = (x[62:52] == 11'h7ff) && (x[51:0] != '0);
        return {x[63] && !nan && (x[62:0] != '0), nan && !x[51]};
    endfunction

    function automatic string req_of(input logic [63:0] x);
        if (x[62:52] == 11'h7ff && x[51:0] != '0) return x[51] ? "R2" : "R3";
        if (x[62:0] == '0) return "R2";
        if (x[63]) return "R1";
        if (x[62:52] == 11'h7ff) return "R2";
        if (x[62:52] == '0) return "R5";
        return x[52] ? "R4" : "R6";
    endfunction

    task automatic run_op(input logic [63:0] x, output logic [63:0] res,
                          output logic [1:0] flags, output int lat);
        @(negedge clk);
        start_i = 1'b1; operand_i = x;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
        flags = {invalid_sqrt_o, invalid_snan_o};
    endtask

    task automatic test_op(input logic [63:0] x, input logic [63:0] exp_res,
                           input logic [1:0] exp_flags, input string req);
        logic [63:0] res;
        logic [1:0]  flags;
        int lat;
        run_op(x, res, flags, lat);
        check(res == exp_res, req, $sformatf("result for %h", x), res, exp_res);
        check(flags == exp_flags, req, $sformatf("flags for %h", x), 64'(flags), 64'(exp_flags));
        if (is_special(x))
            check(lat == 1, "R7", "special latency", 64'(lat), 64'd1);
        else
            check(lat <= 40, "R7", "latency bound", 64'(lat), 64'd40);
        @(negedge clk);
        check(done_o == 1'b0, "R7", "done pulse width", 64'(done_o), 64'd0);
    endtask

    task automatic test_model(input logic [63:0] x);
        test_op(x, model_res(x), model_flags(x), req_of(x));
    endtask

    function automatic logic [63:0] rand_operand();
        logic [63:0] f;
        int unsigned k;
        f = {$urandom, $urandom};
        k = $urandom % 10;
        if (k < 6)  return {1'b0, 11'(1 + ($urandom % 2046)), f[51:0]};
        if (k == 6) return {1'b0, 11'd0, f[51:0] | 52'd1};
        if (k == 7) return {1'b1, 11'($urandom % 2048), f[51:0]};
        if (k == 8) return {f[63], 11'h7ff, f[51:0]};
        return {f[63], f[0] ? 11'h7ff : 11'd0, 52'd0};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(done_o == 1'b0, "R10", "done in reset", 64'(done_o), 64'd0);
        check(result_o == '0, "R10", "result in reset", result_o, 64'd0);
        check({invalid_sqrt_o, invalid_snan_o} == 2'b00, "R10", "flags in reset",
              64'({invalid_sqrt_o, invalid_snan_o}), 64'd0);
        rst_n = 1'b1;

        // directed corner cases
        test_op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'b00, "R2");
        test_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, "R2");
        test_op(64'h7ff0_0000_0000_0000, 64'h7ff0_0000_0000_0000, 2'b00, "R2");
        test_op(64'hfff8_0000_0000_0042, 64'hfff8_0000_0000_0042, 2'b00, "R2");
        test_op(64'hfff0_0000_0000_0000, 64'h7ff8_0000_0000_0000, 2'b10, "R1");
        test_op(64'hbff0_0000_0000_0000, 64'h7ff8_0000_0000_0000, 2'b10, "R1");
        test_op(64'h8000_0000_0000_0001, 64'h7ff8_0000_0000_0000, 2'b10, "R1");
        test_op(64'hfff1_2345_6789_abcd, 64'hfff9_2345_6789_abcd, 2'b01, "R3");
        test_op(64'h3ff0_0000_0000_0000, 64'h3ff0_0000_0000_0000, 2'b00, "R4");
        test_op(64'h4010_0000_0000_0000, 64'h4000_0000_0000_0000, 2'b00, "R4");
        test_op(64'h4008_0000_0000_0000, 64'h3ffb_b67a_e858_4caa, 2'b00, "R4");
        test_op(64'h7fd0_0000_0000_0000, 64'h5fe0_0000_0000_0000, 2'b00, "R4");
        test_op(64'h4000_0000_0000_0000, 64'h3ff6_a09e_667f_3bcd, 2'b00, "R6");
        test_op(64'h0008_0000_0000_0000, 64'h1ff6_a09e_667f_3bcd, 2'b00, "R6");
        test_op(64'h0004_0000_0000_0000, 64'h1ff0_0000_0000_0000, 2'b00, "R5");
        test_op(64'h0002_0000_0000_0000, 64'h1fe6_a09e_667f_3bcd, 2'b00, "R5");
        test_op(64'h0000_0000_0000_0002, 64'h1e66_a09e_667f_3bcd, 2'b00, "R5");
        test_op(64'h0000_0000_0000_0001, 64'h1e60_0000_0000_0000, 2'b00, "R5");
        test_model(64'h7fef_ffff_ffff_ffff);
        test_model(64'h0010_0000_0000_0000);
        test_model(64'h000f_ffff_ffff_ffff);

        // R8: a second start while busy is ignored
        begin
            int dones = 0;
            logic [63:0] first_res = '0;
            @(negedge clk);
            start_i = 1'b1; operand_i = 64'h4010_0000_0000_0000;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            start_i = 1'b1; operand_i = 64'h4022_0000_0000_0000;
            @(negedge clk);
            start_i = 1'b0;
            for (int i = 0; i < 60; i++) begin
                if (done_o) begin
                    dones++;
                    if (dones == 1) first_res = result_o;
                end
                @(negedge clk);
            end
            check(dones == 1, "R8", "done count with busy start", 64'(dones), 64'd1);
            check(first_res == 64'h4000_0000_0000_0000, "R8", "result of first operand",
                  first_res, 64'h4000_0000_0000_0000);
        end

        // R9: outputs held while idle and the operand changes
        begin
            logic [65:0] held;
            bit same = 1'b1;
            held = {result_o, invalid_sqrt_o, invalid_snan_o};
            for (int i = 0; i < 20; i++) begin
                operand_i = {$urandom, $urandom};
                @(negedge clk);
                if ({result_o, invalid_sqrt_o, invalid_snan_o} != held) same = 1'b0;
            end
            check(same, "R9", "outputs held between completions",
                  result_o, held[65:2]);
        end

        // constrained random mix
        for (int n = 0; n < 400; n++) test_model(rand_operand());

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule